// File: doc/BRIEF.md
# Pseudo-Carry Lookahead Adder

A combinational binary adder that sums two unsigned operands and a carry-in, producing the sum word and a carry-out. It does not pass the true carry between bit positions. It passes a pseudo-carry H instead. At bit i the pseudo-carry obeys H(i+1) = g(i) | t(i-1)·H(i). Here g is the bit generate (a AND b) and t is the bit transmit (a OR b). Every generate implies a transmit, so each term of a 4-bit group reduces to at most four inputs, against five for a classic lookahead group. The true carry is recovered where it is needed as C(i+1) = t(i)·H(i+1). Each sum bit is the half-sum p(i) = a XOR b, XORed with t(i-1)·H(i).

The word is cut into 4-bit groups. Each group forms a carry-in-free pseudo-carry and a group transmit, which is the AND of the transmits from one bit below the group up to its third bit. A second lookahead level joins four groups into a 16-bit cluster. It forms the pseudo-carry at every group boundary in two-level sum-of-products form. Clusters are chained by one AND-OR stage each. The carry-in enters as a virtual bit below bit 0 whose generate and transmit both equal cin, so H(0) = cin.

Top module: `pcla_adder`

## Requirements
- R1: For any operands, `sum` equals (a + b + cin) modulo 2^WIDTH.
- R2: `cout` equals bit WIDTH of the full sum a + b + cin.
- R3: With a = b = 0, `cin` alone gives sum = 1 and cout = 0. With cin = 0 the result is 0 and 0.
- R4: A carry that ripples the full width (a = all ones, b = 0, cin = 1) gives sum = 0 and cout = 1.
- R5: a = b = all ones gives sum = all ones except bit 0, where bit 0 equals cin, and cout = 1.
- R6: Complementary alternating operands (0xAAAAAAAA + 0x55555555, in either order) give sum = all ones with cin = 0. With cin = 1 they give sum = 0 and cout = 1.
- R7: The carry into every group boundary bit 4k is exact. For a = 2^(4k) - 1, b = 0, cin = 1, the sum is 2^(4k), and cout = 0 for 4k < WIDTH.
- R8: A carry generated only at the top bit (a = b = 2^(WIDTH-1), cin = 0) gives sum = 0 and cout = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum word |
| cout | output | 1 | Carry out of the top bit |

## Verification
The checker takes for granted that `a`, `b` and `cin` hold settled two-state values whenever its combinational assertions evaluate. It relies on this to compare the pseudo-carry at each group boundary against a ripple-carry reference. It also checks that a true carry never appears without its pseudo-carry. The bench keeps within that assumption: it drives only 0/1 values, changes them just after a rising clock edge, and samples results at the following falling edge.

// File: rtl/pcla_pkg.sv
package pcla_pkg;
  localparam int unsigned GRP_W  = 4;   // bits per group
  localparam int unsigned CLU_G  = 4;   // groups per cluster

  function automatic logic bit_gen(input logic x, input logic y);
    return x & y;
  endfunction

  function automatic logic bit_xmit(input logic x, input logic y);
    return x | y;
  endfunction

  function automatic logic bit_half(input logic x, input logic y);
    return x ^ y;
  endfunction

  // carry-in-free pseudo-carry out of a 4-bit group (fan-in 4 per term)
  function automatic logic grp_pseudo(input logic [3:0] g, input logic [3:0] t);
    return g[3] | g[2] | (t[2] & g[1]) | (t[2] & t[1] & g[0]);
  endfunction

  // group transmit, shifted down by one position
  function automatic logic grp_xmit(input logic [3:0] t, input logic t_below);
    return t[2] & t[1] & t[0] & t_below;
  endfunction
endpackage

// File: rtl/pcla_group.sv
module pcla_group
  import pcla_pkg::*;
(
  input  logic [3:0] g,
  input  logic [3:0] t,
  input  logic [3:0] p,
  input  logic       t_below,
  input  logic       h_in,
  output logic       gh,
  output logic       gt,
  output logic [3:0] s
);
  logic [3:0] t_lo;
  logic [4:0] h_int;

  assign t_lo     = {t[2:0], t_below};
  assign h_int[0] = h_in;
  assign gh       = grp_pseudo(g, t);
  assign gt       = grp_xmit(t, t_below);

  for (genvar j = 0; j < 4; j++) begin : g_bit
    assign h_int[j+1] = g[j] | (t_lo[j] & h_int[j]);
    assign s[j]       = p[j] ^ (t_lo[j] & h_int[j]);
  end
endmodule

// File: rtl/pcla_la4.sv
module pcla_la4 (
  input  logic [3:0] gh,
  input  logic [3:0] gt,
  input  logic       h_in,
  output logic [3:0] h_grp,
  output logic       ch,
  output logic       ct
);
  always_comb begin
    for (int m = 0; m < 4; m++) begin
      logic v;
      logic tp;
      v = 1'b0;
      for (int j = 0; j < m; j++) begin
        tp = 1'b1;
        for (int k = j + 1; k < m; k++) tp = tp & gt[k];
        v = v | (gh[j] & tp);
      end
      tp = 1'b1;
      for (int k = 0; k < m; k++) tp = tp & gt[k];
      h_grp[m] = v | (tp & h_in);
    end
  end

  assign ch = gh[3] | (gt[3] & gh[2]) | (gt[3] & gt[2] & gh[1]) |
              (gt[3] & gt[2] & gt[1] & gh[0]);
  assign ct = &gt;
endmodule

// File: rtl/pcla_adder.sv
module pcla_adder
  import pcla_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int unsigned NGRP = WIDTH / GRP_W;
  localparam int unsigned NCL  = NGRP / CLU_G;

  logic [WIDTH-1:0] g, t, p, t_lo;
  logic [NGRP-1:0]  gh, gt;
  logic [NGRP:0]    h_bnd;
  logic [NCL:0]     h_cl;
  logic [NCL-1:0]   ch, ct;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bits
    assign g[i] = bit_gen(a[i], b[i]);
    assign t[i] = bit_xmit(a[i], b[i]);
    assign p[i] = bit_half(a[i], b[i]);
  end

  // virtual bit -1 carries cin as its transmit
  assign t_lo = {t[WIDTH-2:0], cin};

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    pcla_group u_grp (
      .g       (g[GRP_W*k +: GRP_W]),
      .t       (t[GRP_W*k +: GRP_W]),
      .p       (p[GRP_W*k +: GRP_W]),
      .t_below (t_lo[GRP_W*k]),
      .h_in    (h_bnd[k]),
      .gh      (gh[k]),
      .gt      (gt[k]),
      .s       (sum[GRP_W*k +: GRP_W])
    );
  end

  assign h_cl[0] = cin;

  for (genvar c = 0; c < NCL; c++) begin : g_clu
    pcla_la4 u_la (
      .gh    (gh[CLU_G*c +: CLU_G]),
      .gt    (gt[CLU_G*c +: CLU_G]),
      .h_in  (h_cl[c]),
      .h_grp (h_bnd[CLU_G*c +: CLU_G]),
      .ch    (ch[c]),
      .ct    (ct[c])
    );
    assign h_cl[c+1] = ch[c] | (ct[c] & h_cl[c]);
  end

  assign h_bnd[NGRP] = h_cl[NCL];
  assign cout        = t[WIDTH-1] & h_bnd[NGRP];
endmodule

// File: rtl/pcla_chk.sv
module pcla_chk #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned NGRP  = 8
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [NGRP:0]    h_bnd,
  input logic [WIDTH-1:0] t_bit
);
  logic [WIDTH:0] ref_full;
  logic [WIDTH:0] c_true;

  assign ref_full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    c_true[0] = cin;
    for (int i = 0; i < WIDTH; i++)
      c_true[i+1] = (a[i] & b[i]) | (a[i] & c_true[i]) | (b[i] & c_true[i]);
  end

  always_comb begin
    assert_sum_R1: assert (sum == ref_full[WIDTH-1:0]);
    assert_cout_R2: assert (cout == ref_full[WIDTH]);
    for (int k = 1; k <= NGRP; k++) begin
      assert_bnd_carry_R7: assert (c_true[4*k] == (t_bit[4*k-1] & h_bnd[k]));
      assert_h_covers_R7: assert (!c_true[4*k] || h_bnd[k]);
    end
  end
endmodule

bind pcla_adder pcla_chk #(.WIDTH(WIDTH), .NGRP(NGRP)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
  .h_bnd(h_bnd), .t_bit(t)
);

// File: tb/tb_pcla_adder.sv
module tb_pcla_adder;
  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;
  int           n_run = 0, n_fail = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  pcla_adder #(.WIDTH(W)) dut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  task automatic chk(input string req, input logic [W-1:0] va, input logic [W-1:0] vb,
                     input logic vc, input logic [W-1:0] es, input logic ec);
    @(posedge clk);
    a = va; b = vb; cin = vc;
    @(negedge clk);
    n_run++;
    if (sum !== es || cout !== ec) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%b_%h expected=%b_%h",
               req, va, vb, vc, cout, sum, ec, es);
    end
  endtask

  task automatic t_reset();
    // idle inputs during reset: zero result (R3)
    chk("R3", '0, '0, 1'b0, '0, 1'b0);
  endtask

  task automatic t_cin_only();
    chk("R3", '0, '0, 1'b1, 32'h1, 1'b0);
  endtask

  task automatic t_full_chain();
    chk("R4", '1, '0, 1'b1, '0, 1'b1);
    chk("R4", '0, '1, 1'b1, '0, 1'b1);
  endtask

  task automatic t_all_ones();
    chk("R5", '1, '1, 1'b0, 32'hFFFF_FFFE, 1'b1);
    chk("R5", '1, '1, 1'b1, 32'hFFFF_FFFF, 1'b1);
  endtask

  task automatic t_alternate();
    chk("R6", 32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 32'hFFFF_FFFF, 1'b0);
    chk("R6", 32'h5555_5555, 32'hAAAA_AAAA, 1'b1, 32'h0, 1'b1);
  endtask

  task automatic t_boundary();
    for (int k = 1; k < 8; k++) begin
      logic [W-1:0] m;
      m = (32'h1 << (4*k)) - 32'h1;
      chk("R7", m, '0, 1'b1, m + 32'h1, 1'b0);
    end
  endtask

  task automatic t_msb_gen();
    chk("R8", 32'h8000_0000, 32'h8000_0000, 1'b0, '0, 1'b1);
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] ra, rb;
      logic         rc;
      logic [W:0]   e;
      ra = $urandom; rb = $urandom; rc = 1'($urandom);
      e  = {1'b0, ra} + {1'b0, rb} + {{W{1'b0}}, rc};
      chk("R1_R2", ra, rb, rc, e[W-1:0], e[W]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    rst_n = 1'b1;
    t_cin_only();
    t_full_chain();
    t_all_ones();
    t_alternate();
    t_boundary();
    t_msb_gen();
    t_random();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule